// File: doc/BRIEF.md
# Receive Ring Completion Writer

This block closes out descriptors on one receive DMA ring. The ring holds a power-of-two number of 16-byte descriptors, and the block tracks two indices over it. The producer index belongs to hardware and points at the next descriptor to complete. The consumer index belongs to software and marks how far software has drained the ring. When the receive datapath reports that a segment has finished, the block accepts the report if the ring has room. It then emits the updated status dword of that descriptor for write-back to memory and advances the producer index. It also raises an interrupt request, but only when the posted descriptor had its interrupt-enable bit set.

The status dword is the third 32-bit word of the descriptor. Its low half holds the length and the end-of-frame code. Its upper half holds the flags byte, which carries the start-of-frame code, the error flags and the done flag, followed by the offset byte. A level output reports when the number of completed descriptors not yet consumed reaches a watermark that software programs.

Descriptor fetch, the address words and the data movement itself belong to neighbouring blocks.

Top module: `rx_cmpl_writer`

## Requirements
- R1: After reset the producer and consumer indices are zero, and `wb_valid`, `irq` and `idx_reg` are all zero.
- R2: `idx_reg[15:0]` carries the consumer index and `idx_reg[31:16]` carries the producer index, both zero-extended.
- R3: A segment is taken in a cycle where `seg_valid` and `seg_ready` are both high. In the next cycle `wb_valid` is high for exactly one cycle, `wb_index` equals the producer index from before the take, and the producer index has advanced by one.
- R4: The producer index wraps from RING_DEPTH-1 to 0.
- R5: The ring is full when (producer + 1) mod RING_DEPTH equals the consumer index. While it is full, `seg_ready` is low and `seg_valid` has no effect: there is no write-back, no interrupt and the producer index does not move.
- R6: `wb_dw2` holds the following fields: length in bits 11:0, EOF code in bits 15:12, SOF code in bits 19:16, CRC error in bit 20, done in bit 21, overrun in bit 22, interrupt enable in bit 23 and offset in bits 31:24. The done bit is 1 on every write-back.
- R7: `irq` pulses high for one cycle, in the same cycle as `wb_valid`, only when the taken segment had `seg_ie` set.
- R8: When `ci_wr` is high, the consumer index takes `ci_wdata` mod RING_DEPTH in the next cycle. Otherwise it holds its value.
- R9: `wmark_hit` is high exactly when (producer − consumer) mod RING_DEPTH is at least `wmark_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | A segment has finished and its report is present |
| seg_ready | output | 1 | The ring has room, so a report is taken |
| seg_len | input | 12 | Byte count of the segment |
| seg_eof | input | 4 | End-of-frame code |
| seg_sof | input | 4 | Start-of-frame code |
| seg_crc_err | input | 1 | CRC error seen (frame mode) |
| seg_overrun | input | 1 | Buffer overrun seen |
| seg_ie | input | 1 | Interrupt-enable bit of the posted descriptor |
| seg_offset | input | 8 | Offset byte carried into the status dword |
| ci_wr | input | 1 | Software writes the consumer index |
| ci_wdata | input | 16 | New consumer index value |
| wmark_lvl | input | IW | Watermark level in descriptors |
| idx_reg | output | 32 | Index register view |
| wb_valid | output | 1 | Status dword write-back strobe |
| wb_index | output | IW | Ring slot to write back |
| wb_dw2 | output | 32 | Updated status dword |
| irq | output | 1 | Interrupt request pulse |
| wmark_hit | output | 1 | Watermark reached |

## Verification
The bench drives the producer index around the ring until it reaches the full condition. It then offers segments while the ring is full. A design that tests for full with the wrong off-by-one would overwrite a slot software has not consumed, or would stall one descriptor early. The bench also advances the index past the top slot. A wrong wrap would write back out of range. Field values are chosen so that every flag and code can be told apart, which catches swapped bit positions and a done bit that is not set. Interrupt-enable is toggled from one segment to the next, so an interrupt that fires regardless of the enable bit, or lasts more than one cycle, is caught. Consumer writes above the ring size and watermark levels on both sides of the current occupancy expose wrong masking and a wrong threshold comparison.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  // Completed segment report as seen by the packer
  typedef struct packed {
    logic [7:0]  offset;
    logic        ie;
    logic        overrun;
    logic        crc_err;
    logic [3:0]  sof;
    logic [3:0]  eof;
    logic [11:0] len;
  } seg_info_t;

  localparam int LEN_W    = 12;
  localparam int DONE_BIT = 21;
  localparam int IE_BIT   = 23;

  // Status dword: eof_len half then flags/sof byte then offset byte
  function automatic logic [31:0] pack_status(seg_info_t s);
    logic [7:0] flags;
    flags = {s.ie, s.overrun, 1'b1, s.crc_err, s.sof};
    return {s.offset, flags, s.eof, s.len};
  endfunction

endpackage

// File: rtl/rxc_ring_index.sv
module rxc_ring_index #(
  parameter int RING_DEPTH = 16,
  localparam int IW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          ci_wr,
  input  logic [15:0]   ci_wdata,
  output logic [IW-1:0] pi,
  output logic [IW-1:0] ci,
  output logic          full,
  output logic [IW-1:0] occupancy
);

  // Power-of-two depth: IW-bit arithmetic gives the modulo for free
  function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] x);
    return x + 1'b1;
  endfunction

  function automatic logic [IW-1:0] wrap_diff(logic [IW-1:0] a, logic [IW-1:0] b);
    return a - b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pi <= '0;
      ci <= '0;
    end else begin
      if (adv)   pi <= wrap_inc(pi);
      if (ci_wr) ci <= ci_wdata[IW-1:0];
    end
  end

  assign full      = (wrap_inc(pi) == ci);
  assign occupancy = wrap_diff(pi, ci);

  assert_pi_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pi == IW'($past(pi) + 1'b1)));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(pi));
  assert_ci_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ci_wr |=> $stable(ci));

endmodule

// File: rtl/rxc_irq_status.sv
module rxc_irq_status #(
  parameter int RING_DEPTH = 16,
  localparam int IW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post,
  input  logic          post_ie,
  input  logic [IW-1:0] occupancy,
  input  logic [IW-1:0] wmark_lvl,
  output logic          irq,
  output logic          wmark_hit
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= post & post_ie;
  end

  assign wmark_hit = (occupancy >= wmark_lvl);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(post));

endmodule

// File: rtl/rx_cmpl_writer.sv
module rx_cmpl_writer
  import rxc_pkg::*;
#(
  parameter int RING_DEPTH = 16,
  localparam int IW = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_valid,
  output logic          seg_ready,
  input  logic [11:0]   seg_len,
  input  logic [3:0]    seg_eof,
  input  logic [3:0]    seg_sof,
  input  logic          seg_crc_err,
  input  logic          seg_overrun,
  input  logic          seg_ie,
  input  logic [7:0]    seg_offset,
  input  logic          ci_wr,
  input  logic [15:0]   ci_wdata,
  input  logic [IW-1:0] wmark_lvl,
  output logic [31:0]   idx_reg,
  output logic          wb_valid,
  output logic [IW-1:0] wb_index,
  output logic [31:0]   wb_dw2,
  output logic          irq,
  output logic          wmark_hit
);

  logic [IW-1:0] pi, ci, occupancy;
  logic          full;
  logic          take;
  seg_info_t     info;

  assign seg_ready = ~full;
  assign take      = seg_valid & ~full;

  assign info = '{offset: seg_offset, ie: seg_ie, overrun: seg_overrun,
                  crc_err: seg_crc_err, sof: seg_sof, eof: seg_eof, len: seg_len};

  rxc_ring_index #(.RING_DEPTH(RING_DEPTH)) u_index (
    .clk(clk), .rst_n(rst_n), .adv(take), .ci_wr(ci_wr), .ci_wdata(ci_wdata),
    .pi(pi), .ci(ci), .full(full), .occupancy(occupancy)
  );

  rxc_irq_status #(.RING_DEPTH(RING_DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .post(take), .post_ie(seg_ie),
    .occupancy(occupancy), .wmark_lvl(wmark_lvl), .irq(irq), .wmark_hit(wmark_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_index <= '0;
      wb_dw2   <= '0;
    end else begin
      wb_valid <= take;
      if (take) begin
        wb_index <= pi;
        wb_dw2   <= pack_status(info);
      end
    end
  end

  assign idx_reg = {16'(pi), 16'(ci)};

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_dw2[DONE_BIT]);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wb_valid && wb_dw2[IE_BIT]));
  assert_wb_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_index == IW'(idx_reg[31:16] - 1'b1)));

endmodule

// File: tb/test_rx_cmpl_writer.sv
`timescale 1ns/1ps
module test_rx_cmpl_writer;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic seg_valid = 0, seg_crc_err = 0, seg_overrun = 0, seg_ie = 0, ci_wr = 0;
  logic [11:0] seg_len = 0;
  logic [3:0]  seg_eof = 0, seg_sof = 0;
  logic [7:0]  seg_offset = 0;
  logic [15:0] ci_wdata = 0;
  logic [IW-1:0] wmark_lvl = 0;
  logic seg_ready, wb_valid, irq, wmark_hit;
  logic [31:0] idx_reg, wb_dw2;
  logic [IW-1:0] wb_index;

  int checks = 0, errors = 0;
  int m_pi = 0, m_ci = 0;

  always #2.5 clk = ~clk;

  rx_cmpl_writer #(.RING_DEPTH(N)) i_rx_cmpl_writer (.*);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: model predicts, design steps, compare after the edge
  task automatic step();
    bit rdy, take;
    longint dw;
    rdy  = ((m_pi + 1) % N) != m_ci;
    check("R5 seg_ready", seg_ready, rdy);
    take = seg_valid && rdy;
    dw = seg_len + (longint'(seg_eof) << 12) + (longint'(seg_sof) << 16)
       + (longint'(seg_crc_err) << 20) + (longint'(1) << 21)
       + (longint'(seg_overrun) << 22) + (longint'(seg_ie) << 23)
       + (longint'(seg_offset) << 24);
    @(posedge clk); #1;
    check("R3 wb_valid", wb_valid, take);
    check("R7 irq", irq, take && seg_ie);
    if (take) begin
      check("R3 wb_index", wb_index, m_pi);
      check("R6 wb_dw2", wb_dw2, dw);
      m_pi = (m_pi + 1) % N;
    end
    if (ci_wr) m_ci = ci_wdata % N;
    check("R2 idx_reg", idx_reg, m_pi * 65536 + m_ci);
    check("R9 wmark_hit", wmark_hit, ((m_pi - m_ci + N) % N) >= wmark_lvl);
  endtask

  task automatic seg(int len, int eof, int sof, bit crc, bit ovr, bit ie, int off);
    seg_valid = 1; seg_len = 12'(len); seg_eof = 4'(eof); seg_sof = 4'(sof);
    seg_crc_err = crc; seg_overrun = ovr; seg_ie = ie; seg_offset = 8'(off);
    step();
    seg_valid = 0;
  endtask

  task automatic ci_write(int v);
    ci_wr = 1; ci_wdata = 16'(v);
    step();
    ci_wr = 0;
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 idx_reg", idx_reg, 0);
    check("R1 wb_valid", wb_valid, 0);
    check("R1 irq", irq, 0);
    step();
    // R6 distinct field patterns, R7 interrupt gating
    seg(12'hABC, 4'h5, 4'h9, 1, 0, 0, 8'h3C);
    seg(12'h001, 4'hF, 4'h0, 0, 1, 1, 8'hC3);
    seg(12'hFFF, 4'h0, 4'hF, 1, 1, 1, 8'h00);
    seg(12'h000, 4'hA, 4'h6, 0, 0, 0, 8'hFF);
    step();
    // R9 watermark on both sides of occupancy 4
    wmark_lvl = 4; step();
    wmark_lvl = 5; step();
    // R5 fill the ring until full
    for (int k = 0; k < N && ((m_pi + 1) % N) != m_ci; k++)
      seg(k * 7 + 1, k, 15 - k, k[0], k[1], k[2], k * 3);
    check("R5 full reached", seg_ready, 0);
    // R5 offers while full are ignored
    seg(12'h123, 1, 2, 1, 1, 1, 8'h55);
    seg(12'h456, 3, 4, 0, 0, 1, 8'hAA);
    check("R5 pi held", idx_reg[31:16], N - 1);
    // R8 consumer write above ring size is taken mod N
    ci_write(16'h0024);
    // R4 wrap of producer past top slot
    seg(12'h010, 1, 1, 0, 0, 1, 1);
    check("R4 pi wrapped", idx_reg[31:16], 0);
    seg(12'h020, 2, 2, 0, 0, 0, 2);
    seg(12'h030, 3, 3, 1, 0, 1, 3);
    // R8 simultaneous consume and post
    ci_wr = 1; ci_wdata = 16'd3;
    seg(12'h040, 4, 4, 0, 1, 0, 4);
    ci_wr = 0;
    wmark_lvl = 1; step();
    ci_write(m_pi); // empty ring
    wmark_lvl = 0; step();
    wmark_lvl = 1; step();
    repeat (2) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule